// File: doc/BRIEF.md
# Embedded-Sync Video Capture with Region Filter

This block sits behind a parallel video input and runs on the pixel clock. It takes one element per clock. Frame timing comes only from the four-byte timing codes carried inside the data stream: there are no separate sync pins. From those codes it tracks the field, vertical blanking and horizontal phase of each element. It then forwards to a downstream valid/data sink only the elements that the current configuration selects. The timing codes themselves are never forwarded.

A mode input picks the region that survives. In one mode the whole field passes. In another, only active picture passes. In the third, only the vertical-blanking lines pass, where ancillary data is carried. Two reductions can be added on top of any mode:

- **Field skip** drops the second field of an interlaced stream.
- **Element skip** keeps only the even-indexed or only the odd-indexed elements of each line segment. On 4:2:2 YCbCr this gives chroma-only or luma-only output.

A programmable row length and row count crop the active picture, so small formats can be captured from any stream. The element width is a parameter of 8 or 16 bits. A start-of-field flag marks the first element forwarded from each new field.

Top module: `vid_region_capture`

## Requirements
- R1: After reset `out_valid` and `out_sof` are 0, and no element is forwarded until a first timing code has been received.
- R2: A timing code is the low byte sequence FF, 00, 00 followed by a status byte. In the status byte, bit 6 is the field bit F, bit 5 is the blanking bit V, and bit 4 is H (0 = start of active line, 1 = end of active line). None of the four code elements is ever forwarded. A sequence that differs from the preamble, such as FF, 00, 55, is ordinary data.
- R3: With `cfg_mode` 0 or 3, every non-code element after synchronisation is forwarded, subject to R6 to R9.
- R4: With `cfg_mode` 1, only elements that follow a start-of-line code on lines whose V bit is 0 are forwarded.
- R5: With `cfg_mode` 2, only elements received while the last code carried V = 1 are forwarded. This covers both halves of those lines.
- R6: An active-picture element whose column index is at least `cfg_row_len` is dropped. The column index is 0 for the first element after a start-of-line code.
- R7: An active-picture element on an active line whose index is at least `cfg_rows` is dropped. The line index counts end-of-line codes with V = 0 since the last code with V = 1.
- R8: When `cfg_field_skip` is 1, elements received while the last code carried F = 1 are dropped.
- R9: `cfg_elem_skip` 1 keeps only even-indexed elements and 2 keeps only odd-indexed elements; 0 and 3 keep all. The index restarts at 0 after every timing code and counts each element.
- R10: `out_sof` is 1 together with `out_valid` on the first forwarded element after a timing code whose F bit differs from that of the previous code, or after the first code since reset.
- R11: An element sampled at rising edge k appears on `out_data` after edge k+3. Forwarded elements keep their input order.
- R12: With a 16-bit element width, codes are recognised on the low byte only, and forwarded words carry all 16 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Region select: 0/3 all, 1 active only, 2 vertical blanking only |
| cfg_field_skip | input | 1 | Drop elements of field F = 1 |
| cfg_elem_skip | input | 2 | 1 keep even elements, 2 keep odd, 0/3 keep all |
| cfg_row_len | input | ROW_W | Active elements kept per line |
| cfg_rows | input | LINE_W | Active lines kept per field |
| vin_data | input | DATA_W | Incoming element, one per clock |
| out_valid | output | 1 | Forwarded element present |
| out_data | output | DATA_W | Forwarded element |
| out_sof | output | 1 | First forwarded element of a new field |

## Verification
Each element reaches the outputs exactly three edges after the edge that samples it. A recognised code silences the output for the three edges that follow it. The bench therefore captures outputs at falling edges into a list, in order. At the end of each scenario it compares that list with the one its own model of the requirements predicts. Every scenario ends with a complete timing code, so the pipeline is drained before the design is reset. The three-edge latency itself is checked cycle by cycle, one falling edge before and one after the element is due.

// File: rtl/vrc_pkg.sv
// Shared types and constants for the region-filtering video capture.
package vrc_pkg;

    // Region selection applied by the tracker.
    typedef enum logic [1:0] {
        CAP_ALL     = 2'd0,
        CAP_ACTIVE  = 2'd1,
        CAP_VBLANK  = 2'd2,
        CAP_ALL_ALT = 2'd3
    } cap_mode_e;

    // Element-skip selection.
    typedef enum logic [1:0] {
        SKIP_NONE     = 2'd0,
        SKIP_KEEP_EVN = 2'd1,
        SKIP_KEEP_ODD = 2'd2,
        SKIP_NONE_ALT = 2'd3
    } skip_mode_e;

    // Timing-code status bits, as decoded from the fourth code byte.
    typedef struct packed {
        logic f;   // field
        logic v;   // vertical blanking
        logic h;   // 1 = end of active line, 0 = start
    } tcode_t;

    localparam logic [7:0] PRE_HI = 8'hFF;
    localparam logic [7:0] PRE_LO = 8'h00;
    // Number of preamble elements preceding the status byte.
    localparam int unsigned PRE_LEN = 3;
    // Bit positions inside the status byte.
    localparam int unsigned XY_F = 6;
    localparam int unsigned XY_V = 5;
    localparam int unsigned XY_H = 4;

endpackage

// File: rtl/vrc_code_detect.sv
// Timing-code recogniser.
// Watches the low byte of each element and keeps a short history of the
// previous PRE_LEN bytes. When the history holds the preamble, the current
// byte is the status byte: hit pulses for that cycle and its bits are decoded.
// Assumes one element per clock and that FF/00 do not occur as a preamble
// pattern inside ordinary data.
module vrc_code_detect
    import vrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] lb,
    output logic       hit,
    output tcode_t     code
);

    logic [7:0] hist_q [PRE_LEN];

    // Shift the low-byte history, newest at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(PRE_LEN); i++) hist_q[i] <= 8'h01;
        end else begin
            hist_q[0] <= lb;
            for (int i = 1; i < int'(PRE_LEN); i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Match the oldest byte against FF and the younger ones against 00.
    always_comb begin
        hit = (hist_q[PRE_LEN-1] == PRE_HI);
        for (int i = 0; i < int'(PRE_LEN) - 1; i++) begin
            hit = hit && (hist_q[i] == PRE_LO);
        end
    end

    // Decode the status bits of the current byte.
    always_comb begin
        code.f = lb[XY_F];
        code.v = lb[XY_V];
        code.h = lb[XY_H];
    end

endmodule

// File: rtl/vrc_region_track.sv
// Frame-position tracker and element classifier.
// Holds the F/V/H state of the last timing code, the column index of the
// active line, the active-line index of the field and the element parity.
// For every non-code element it decides, from the configuration, whether the
// element is kept. It also decides whether the element carries the
// start-of-field mark. A mark lost because the element later turned out to be
// a preamble byte is re-armed through killed_sof.
module vrc_region_track
    import vrc_pkg::*;
#(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  tcode_t            code,
    input  logic              killed_sof,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_field_skip,
    input  logic [1:0]        cfg_elem_skip,
    input  logic [ROW_W-1:0]  cfg_row_len,
    input  logic [LINE_W-1:0] cfg_rows,
    output logic              elem_keep,
    output logic              elem_sof
);

    logic              synced_q;
    tcode_t            st_q;
    logic [ROW_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic              par_q;
    logic              pend_q;

    logic in_act, in_vbi, in_crop, reg_ok, fld_ok, par_ok, new_field;

    // Region membership of the element now at the input.
    always_comb begin
        in_act  = synced_q && !st_q.h && !st_q.v;
        in_vbi  = synced_q && st_q.v;
        in_crop = (col_q < cfg_row_len) && (line_q < cfg_rows);
    end

    // Mode-dependent region filter.
    always_comb begin
        unique case (cap_mode_e'(cfg_mode))
            CAP_ACTIVE: reg_ok = in_act && in_crop;
            CAP_VBLANK: reg_ok = in_vbi;
            default:    reg_ok = synced_q && (!in_act || in_crop);
        endcase
    end

    // Field and element-parity filters, and the final keep decision.
    always_comb begin
        fld_ok = !(cfg_field_skip && st_q.f);
        unique case (skip_mode_e'(cfg_elem_skip))
            SKIP_KEEP_EVN: par_ok = !par_q;
            SKIP_KEEP_ODD: par_ok = par_q;
            default:       par_ok = 1'b1;
        endcase
        elem_keep = !hit && reg_ok && fld_ok && par_ok;
        elem_sof  = elem_keep && pend_q;
        new_field = !synced_q || (code.f != st_q.f);
    end

    // Update position state on codes and on ordinary elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            st_q     <= '0;
            col_q    <= '0;
            line_q   <= '0;
            par_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else if (hit) begin
            synced_q <= 1'b1;
            st_q     <= code;
            par_q    <= 1'b0;
            if (!code.h) col_q <= '0;
            if (code.v) begin
                line_q <= '0;
            end else if (code.h && (line_q != '1)) begin
                line_q <= line_q + 1'b1;
            end
            pend_q <= pend_q || new_field || killed_sof;
        end else begin
            if (in_act && (col_q != '1)) col_q <= col_q + 1'b1;
            par_q <= !par_q;
            if (elem_keep) pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/vrc_delay_line.sv
// Hold-back pipeline.
// Elements wait PRE_LEN stages so that preamble bytes, which look like data
// until the status byte arrives, can be discarded. On kill every stage is
// invalidated and the element leaving the last stage (the first preamble
// byte) is not forwarded. The output is registered.
module vrc_delay_line #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              in_keep,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    output logic              killed_sof,
    output logic              out_valid,
    output logic              out_sof,
    output logic [DATA_W-1:0] out_data
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0]  st_v;
    logic [DEPTH-1:0]  st_s;
    logic [DATA_W-1:0] st_d [DEPTH];

    // A start-of-field mark is lost if any valid stage carrying it is killed.
    assign killed_sof = kill && |(st_v & st_s);

    // Advance the stages, or clear them on a recognised code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v <= '0;
            st_s <= '0;
            for (int i = 0; i < int'(DEPTH); i++) st_d[i] <= '0;
        end else begin
            st_v[0] <= in_keep && !kill;
            st_s[0] <= in_sof && !kill;
            st_d[0] <= in_data;
            for (int i = 1; i < int'(DEPTH); i++) begin
                st_v[i] <= st_v[i-1] && !kill;
                st_s[i] <= st_s[i-1] && !kill;
                st_d[i] <= st_d[i-1];
            end
        end
    end

    // Register the element leaving the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= st_v[LAST] && !kill;
            out_sof   <= st_v[LAST] && st_s[LAST] && !kill;
            out_data  <= st_d[LAST];
        end
    end

endmodule

// File: rtl/vid_region_capture.sv
// Capture front end for video with embedded timing codes.
// Recognises codes, classifies each element by field and region, and
// forwards the selected elements with a three-edge latency. Assumes one
// element per clock on vin_data; codes are taken from the low byte.
module vid_region_capture
    import vrc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_field_skip,
    input  logic [1:0]        cfg_elem_skip,
    input  logic [ROW_W-1:0]  cfg_row_len,
    input  logic [LINE_W-1:0] cfg_rows,
    input  logic [DATA_W-1:0] vin_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof
);

    localparam int unsigned HOLD = PRE_LEN;

    logic   code_hit;
    tcode_t code;
    logic   trk_keep;
    logic   trk_sof;
    logic   kill_sof;

    vrc_code_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .lb    (vin_data[7:0]),
        .hit   (code_hit),
        .code  (code)
    );

    vrc_region_track #(
        .ROW_W  (ROW_W),
        .LINE_W (LINE_W)
    ) u_trk (
        .clk            (clk),
        .rst_n          (rst_n),
        .hit            (code_hit),
        .code           (code),
        .killed_sof     (kill_sof),
        .cfg_mode       (cfg_mode),
        .cfg_field_skip (cfg_field_skip),
        .cfg_elem_skip  (cfg_elem_skip),
        .cfg_row_len    (cfg_row_len),
        .cfg_rows       (cfg_rows),
        .elem_keep      (trk_keep),
        .elem_sof       (trk_sof)
    );

    vrc_delay_line #(
        .DATA_W (DATA_W),
        .DEPTH  (HOLD)
    ) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (code_hit),
        .in_keep    (trk_keep),
        .in_sof     (trk_sof),
        .in_data    (vin_data),
        .killed_sof (kill_sof),
        .out_valid  (out_valid),
        .out_sof    (out_sof),
        .out_data   (out_data)
    );

endmodule

// File: rtl/vrc_checker.sv
// Temporal properties of the capture block, bound to every instance.
module vrc_checker (
    input logic clk,
    input logic rst_n,
    input logic code_hit,
    input logic trk_keep,
    input logic trk_sof,
    input logic out_valid,
    input logic out_sof
);

    // R10
    sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R2
    code_quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_hit |=> !out_valid);

    // R2
    code_quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(code_hit) |=> !out_valid);

    // R2
    code_quiet_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(code_hit, 2) |=> !out_valid);

    // R11
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(trk_keep, 4));

    // R10
    sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> $past(trk_sof, 4));

endmodule

bind vid_region_capture vrc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_hit  (code_hit),
    .trk_keep  (trk_keep),
    .trk_sof   (trk_sof),
    .out_valid (out_valid),
    .out_sof   (out_sof)
);

// File: tb/sim_vid_region_capture.sv
module sim_vid_region_capture;

    localparam int CLK_PERIOD = 10;
    localparam int MAXQ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_field_skip = 1'b0;
    logic [1:0]  cfg_elem_skip = 2'd0;
    logic [11:0] cfg_row_len = 12'hFFF;
    logic [10:0] cfg_rows = 11'h7FF;
    logic [7:0]  vin = 8'h01;
    logic        out_valid, out_sof;
    logic [7:0]  out_data;
    logic        w_valid, w_sof;
    logic [15:0] w_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_region_capture u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_field_skip(cfg_field_skip), .cfg_elem_skip(cfg_elem_skip),
        .cfg_row_len(cfg_row_len), .cfg_rows(cfg_rows), .vin_data(vin),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof)
    );

    vid_region_capture #(.DATA_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_field_skip(cfg_field_skip), .cfg_elem_skip(cfg_elem_skip),
        .cfg_row_len(cfg_row_len), .cfg_rows(cfg_rows), .vin_data({~vin, vin}),
        .out_valid(w_valid), .out_data(w_data), .out_sof(w_sof)
    );

    int nchk = 0, nfail = 0, wide_mism = 0, seq = 0;
    logic [7:0] exp_d [MAXQ];
    logic       exp_s [MAXQ];
    logic [7:0] got_d [MAXQ];
    logic       got_s [MAXQ];
    int n_exp = 0, n_got = 0;

    // bench model of the frame position
    bit bs_sync, bs_f, bs_v, bs_h, bs_par, bs_pend;
    int bs_col, bs_line;

    // capture forwarded elements and compare the wide instance
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && n_got < MAXQ) begin
                got_d[n_got] = out_data;
                got_s[n_got] = out_sof;
                n_got++;
            end
            if ((w_valid !== out_valid) || (w_sof !== out_sof) ||
                (out_valid && (w_data !== {~out_data, out_data})))
                wide_mism++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_exp = 0; n_got = 0;
        bs_sync = 0; bs_f = 0; bs_v = 0; bs_h = 0; bs_par = 0; bs_pend = 0;
        bs_col = 0; bs_line = 0;
    endtask

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        vin = b;
    endtask

    task automatic put_elem(input logic [7:0] b);
        bit in_act, in_vbi, crop, reg_ok, par_ok, keep;
        drive(b);
        in_act = bs_sync && !bs_h && !bs_v;
        in_vbi = bs_sync && bs_v;
        crop = (bs_col < int'(cfg_row_len)) && (bs_line < int'(cfg_rows));
        case (cfg_mode)
            2'd1: reg_ok = in_act && crop;
            2'd2: reg_ok = in_vbi;
            default: reg_ok = bs_sync && (!in_act || crop);
        endcase
        case (cfg_elem_skip)
            2'd1: par_ok = !bs_par;
            2'd2: par_ok = bs_par;
            default: par_ok = 1;
        endcase
        keep = reg_ok && par_ok && !(cfg_field_skip && bs_f);
        if (keep) begin
            exp_d[n_exp] = b;
            exp_s[n_exp] = bs_pend;
            n_exp++;
            bs_pend = 0;
        end
        if (in_act) bs_col++;
        bs_par = !bs_par;
    endtask

    task automatic put_new();
        put_elem(8'((seq % 253) + 1));
        seq++;
    endtask

    task automatic put_code(input bit f, input bit v, input bit h);
        drive(8'hFF); drive(8'h00); drive(8'h00);
        drive({1'b1, f, v, h, 4'h0});
        if (!bs_sync || f != bs_f) bs_pend = 1;
        bs_sync = 1; bs_f = f; bs_v = v; bs_h = h; bs_par = 0;
        if (!h) bs_col = 0;
        if (v) bs_line = 0;
        else if (h) bs_line++;
    endtask

    task automatic run_field(input bit f, input int nvbi, input int nact,
                             input int hb, input int av);
        for (int l = 0; l < nvbi + nact; l++) begin
            bit v = (l < nvbi);
            put_code(f, v, 1'b1);
            for (int i = 0; i < hb; i++) put_new();
            put_code(f, v, 1'b0);
            for (int i = 0; i < av; i++) put_new();
        end
    endtask

    // close with a code so all elements drain, then compare the lists
    task automatic finish_cmp(input string req);
        int bad;
        put_code(bs_f, 1'b1, 1'b1);
        @(negedge clk);
        chk(n_got == n_exp, {req, " count"}, n_got, n_exp);
        bad = -1;
        for (int i = 0; i < n_exp && i < n_got; i++)
            if (bad < 0 && (got_d[i] !== exp_d[i] || got_s[i] !== exp_s[i])) bad = i;
        if (bad >= 0)
            chk(0, {req, " content"}, {got_s[bad], got_d[bad]}, {exp_s[bad], exp_d[bad]});
        else
            chk(1, {req, " content"}, 0, 0);
        do_reset();
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(out_valid == 0 && out_sof == 0, "R1 reset outputs", {out_valid, out_sof}, 0);
    endtask

    task automatic t_all_mode();
        cfg_mode = 2'd0;
        for (int i = 0; i < 10; i++) put_new();   // R1: not yet synchronised
        run_field(1'b0, 2, 3, 4, 8);
        run_field(1'b1, 2, 3, 4, 8);
        finish_cmp("R3 R1 R10 all-mode");
    endtask

    task automatic t_active();
        cfg_mode = 2'd1;
        run_field(1'b0, 2, 3, 4, 8);
        run_field(1'b1, 1, 2, 4, 6);
        finish_cmp("R4 active-only");
    endtask

    task automatic t_vblank();
        cfg_mode = 2'd2;
        run_field(1'b0, 3, 2, 4, 6);
        finish_cmp("R5 blanking-only");
    endtask

    task automatic t_row_crop();
        cfg_mode = 2'd1; cfg_row_len = 12'd5;
        run_field(1'b0, 1, 3, 4, 9);
        finish_cmp("R6 row crop");
        cfg_row_len = 12'hFFF;
    endtask

    task automatic t_line_crop();
        cfg_mode = 2'd0; cfg_rows = 11'd2;
        run_field(1'b0, 1, 4, 3, 6);
        run_field(1'b1, 1, 4, 3, 6);
        finish_cmp("R7 line crop");
        cfg_rows = 11'h7FF;
    endtask

    task automatic t_field_skip();
        cfg_mode = 2'd1; cfg_field_skip = 1'b1;
        run_field(1'b0, 1, 2, 3, 6);
        run_field(1'b1, 1, 2, 3, 6);
        run_field(1'b0, 1, 2, 3, 6);
        finish_cmp("R8 R10 field skip");
        cfg_field_skip = 1'b0;
    endtask

    task automatic t_elem_skip();
        cfg_mode = 2'd1; cfg_elem_skip = 2'd2;
        run_field(1'b0, 1, 3, 4, 8);
        finish_cmp("R9 keep odd");
        cfg_mode = 2'd0; cfg_elem_skip = 2'd1;
        run_field(1'b0, 2, 2, 5, 7);
        finish_cmp("R9 keep even");
        cfg_elem_skip = 2'd0;
    endtask

    task automatic t_latency();
        cfg_mode = 2'd0;
        put_code(1'b0, 1'b0, 1'b0);
        drive(8'h42);          // sampled at edge k
        drive(8'h43);
        drive(8'h44);
        drive(8'h45);          // now after edge k+2
        chk(out_valid == 0, "R11 not before k+3", out_valid, 0);
        drive(8'h46);          // now after edge k+3
        chk(out_valid == 1 && out_data == 8'h42, "R11 at k+3", {out_valid, out_data}, 9'h142);
        do_reset();
    endtask

    task automatic t_alt_mode();
        cfg_mode = 2'd3;
        run_field(1'b0, 1, 2, 3, 5);
        finish_cmp("R3 mode 3");
        cfg_mode = 2'd0;
    endtask

    task automatic t_false_pre();
        cfg_mode = 2'd0;
        put_code(1'b0, 1'b0, 1'b0);
        put_elem(8'h10); put_elem(8'hFF); put_elem(8'h00); put_elem(8'h55);
        put_elem(8'hFF); put_elem(8'h00); put_elem(8'h22);
        finish_cmp("R2 false preamble");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_all_mode();
        t_active();
        t_vblank();
        t_row_crop();
        t_line_crop();
        t_field_skip();
        t_elem_skip();
        t_latency();
        t_alt_mode();
        t_false_pre();
        chk(wide_mism == 0, "R12 wide instance", wide_mism, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule